// File: doc/BRIEF.md
# Bit Test-and-Modify Memory Unit

This unit carries out the two read-modify-write bit operations of an 8/16-bit accumulator processor. One operation sets the memory bits that are selected by the accumulator. The other clears them. Both use a two-byte absolute operand address in bank zero. A one-cycle start pulse hands the unit four values: the operation select, the width mode, the accumulator and the program counter of the instruction. The unit captures all four at that point.

It then walks through its sequence on a byte-wide synchronous memory port. It fetches the operand address from the two instruction bytes that follow the program counter. It reads one data byte, or two in little-endian order. It writes the modified value back in the same order. Finally it pulses `done_o`. On that cycle the zero flag, the next program counter, the instruction length and the architectural cycle count are all valid.

The zero flag describes the overlap between the original memory contents and the accumulator. It does not describe the value written back.

Top module: `bitmod_rmw_unit`

## Requirements
- R1: While reset is held, and after it is released, the unit is idle: `busy_o`, `done_o`, `zero_o`, `mem_rd_o` and `mem_wr_o` are all 0.
- R2: The operand address is read from memory at PC+1 (low byte) and PC+2 (high byte). Data bytes sit at that address and at the address plus one, and the 16-bit sum wraps from 0xFFFF to 0x0000.
- R3: With `op_set_i`=1 (set operation), the value written back is the memory value ORed with the accumulator.
- R4: With `op_set_i`=0 (clear operation), the value written back is the memory value ANDed with the inverse of the accumulator.
- R5: `zero_o` is 1 exactly when (original memory value AND accumulator) is zero. A zero written result does not by itself set it.
- R6: With `wide_i`=0, only accumulator bits 7:0 take part. Exactly one byte is written, at the operand address, and the byte above it is left untouched.
- R7: With `wide_i`=1, the low byte is read and written at the operand address and the high byte at the next address, with exactly two writes.
- R8: In the done cycle, `pc_next_o` equals PC+3 and `bytes_o` equals 3. `cycles_o` equals 6 in 8-bit mode and 7 in 16-bit mode.
- R9: `done_o` is high for exactly one cycle, directly after the final write. If the clock edge that samples the start pulse is edge 0, `done_o` goes high after edge 4 in 8-bit mode and after edge 6 in 16-bit mode.
- R10: Each cycle carries at most one memory access: `mem_rd_o` and `mem_wr_o` are never high together, and neither is high while the unit is idle.
- R11: A start pulse that arrives while `busy_o` is high is ignored. This includes a pulse in the done cycle. It starts no new operation, and it does not alter the captured program counter or any memory location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_set_i | input | 1 | 1 selects set-bits, 0 selects clear-bits |
| wide_i | input | 1 | 1 selects 16-bit data, 0 selects 8-bit data |
| acc_i | input | 16 | Accumulator value |
| pc_i | input | 16 | Program counter of the instruction |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rd_o | output | 1 | Read request; data returns on `mem_rdata_i` after the next edge |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Registered read data |
| busy_o | output | 1 | Operation in progress, done cycle included |
| done_o | output | 1 | One-cycle completion pulse |
| zero_o | output | 1 | Zero flag of the last completed operation |
| pc_next_o | output | 16 | Program counter after the instruction |
| bytes_o | output | 2 | Instruction length in bytes |
| cycles_o | output | 3 | Architectural cycle count of the operation |

## Verification
Two events can land on the same clock edge: the completion of one operation and a fresh start request. The bench raises `start_i` in exactly the cycle where `done_o` is high, and it also raises it in the middle of a running operation. It then confirms through the ports that no further memory traffic or done pulse follows, and that the captured program counter and the untouched memory bytes keep their values. A second overlap sits inside the final write cycle, where the flag and the written byte come from the same read data. The bench picks operand and accumulator pairs whose written result and overlap differ in being zero, so a flag taken from the wrong value is exposed.

// File: rtl/bitmod_pkg.sv
package bitmod_pkg;

    // Sequencer steps; each one issues at most one memory access.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH_LO = 3'd1,
        ST_FETCH_HI = 3'd2,
        ST_READ_LO  = 3'd3,
        ST_READ_HI  = 3'd4,
        ST_WRITE_LO = 3'd5,
        ST_WRITE_HI = 3'd6,
        ST_DONE     = 3'd7
    } step_t;

endpackage

// File: rtl/bitmod_alu.sv
module bitmod_alu #(
    parameter  int BYTE_W = 8,
    parameter  int LANES  = 2,
    localparam int VAL_W  = BYTE_W * LANES
) (
    input  logic [VAL_W-1:0] mem_val_i,
    input  logic [VAL_W-1:0] acc_i,
    input  logic             op_set_i,
    input  logic             wide_i,
    output logic [VAL_W-1:0] result_o,
    output logic             zero_o
);

    logic [VAL_W-1:0] acc_eff;

    // Lane 0 always takes part; upper lanes only in wide mode.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [BYTE_W-1:0] a_ln;
        logic [BYTE_W-1:0] m_ln;

        if (ln == 0) begin : g_base
            assign a_ln = acc_i[ln*BYTE_W +: BYTE_W];
        end else begin : g_upper
            assign a_ln = wide_i ? acc_i[ln*BYTE_W +: BYTE_W] : '0;
        end

        assign m_ln = mem_val_i[ln*BYTE_W +: BYTE_W];
        assign acc_eff[ln*BYTE_W +: BYTE_W]  = a_ln;
        assign result_o[ln*BYTE_W +: BYTE_W] = op_set_i ? (m_ln | a_ln) : (m_ln & ~a_ln);
    end

    // Flag comes from the unmodified memory value.
    assign zero_o = ~|(mem_val_i & acc_eff);

endmodule

// File: rtl/bitmod_ctrl.sv
module bitmod_ctrl
    import bitmod_pkg::*;
#(
    parameter  int BYTE_W     = 8,
    parameter  int INSN_LEN   = 3,
    parameter  int NARROW_CYC = 6,
    parameter  int WIDE_CYC   = 7,
    localparam int ADDR_W     = 2 * BYTE_W,
    localparam int VAL_W      = 2 * BYTE_W,
    localparam int CYC_W      = $clog2(WIDE_CYC + 1),
    localparam int LEN_W      = $clog2(INSN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_set_i,
    input  logic              wide_i,
    input  logic [VAL_W-1:0]  acc_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic [VAL_W-1:0]  alu_result_i,
    input  logic              alu_zero_i,
    output logic [VAL_W-1:0]  alu_val_o,
    output logic [VAL_W-1:0]  alu_acc_o,
    output logic              alu_op_set_o,
    output logic              alu_wide_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              zero_o,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic [LEN_W-1:0]  bytes_o,
    output logic [CYC_W-1:0]  cycles_o
);

    typedef struct packed {
        step_t             step;
        logic              op_set;
        logic              wide;
        logic [VAL_W-1:0]  acc;
        logic [ADDR_W-1:0] pc;
        logic [BYTE_W-1:0] addr_lo;
        logic [ADDR_W-1:0] opnd;
        logic [BYTE_W-1:0] data_lo;
        logic [BYTE_W-1:0] hi_res;
        logic              zero;
    } regs_t;

    regs_t r_d, r_q;

    // Read data is registered: the byte requested in one step is
    // present on mem_rdata_i during the next step.
    always_comb begin
        r_d         = r_q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        case (r_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.step   = ST_FETCH_LO;
                    r_d.op_set = op_set_i;
                    r_d.wide   = wide_i;
                    r_d.acc    = acc_i;
                    r_d.pc     = pc_i;
                end
            end
            ST_FETCH_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = r_q.pc + ADDR_W'(1);
                r_d.step   = ST_FETCH_HI;
            end
            ST_FETCH_HI: begin
                mem_rd_o    = 1'b1;
                mem_addr_o  = r_q.pc + ADDR_W'(2);
                r_d.addr_lo = mem_rdata_i;
                r_d.step    = ST_READ_LO;
            end
            ST_READ_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = {mem_rdata_i, r_q.addr_lo};
                r_d.opnd   = {mem_rdata_i, r_q.addr_lo};
                r_d.step   = r_q.wide ? ST_READ_HI : ST_WRITE_LO;
            end
            ST_READ_HI: begin
                mem_rd_o    = 1'b1;
                mem_addr_o  = r_q.opnd + ADDR_W'(1);
                r_d.data_lo = mem_rdata_i;
                r_d.step    = ST_WRITE_LO;
            end
            ST_WRITE_LO: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = r_q.opnd;
                mem_wdata_o = alu_result_i[BYTE_W-1:0];
                r_d.hi_res  = alu_result_i[VAL_W-1:BYTE_W];
                r_d.zero    = alu_zero_i;
                r_d.step    = r_q.wide ? ST_WRITE_HI : ST_DONE;
            end
            ST_WRITE_HI: begin
                mem_wr_o    = 1'b1;
                mem_addr_o  = r_q.opnd + ADDR_W'(1);
                mem_wdata_o = r_q.hi_res;
                r_d.step    = ST_DONE;
            end
            ST_DONE: begin
                r_d.step = ST_IDLE;
            end
            default: begin
                r_d.step = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{step: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Operand for the modify step: little-endian pair or single byte.
    assign alu_val_o    = r_q.wide ? {mem_rdata_i, r_q.data_lo}
                                   : {{BYTE_W{1'b0}}, mem_rdata_i};
    assign alu_acc_o    = r_q.acc;
    assign alu_op_set_o = r_q.op_set;
    assign alu_wide_o   = r_q.wide;

    assign busy_o    = (r_q.step != ST_IDLE);
    assign done_o    = (r_q.step == ST_DONE);
    assign zero_o    = r_q.zero;
    assign pc_next_o = r_q.pc + ADDR_W'(INSN_LEN);
    assign bytes_o   = LEN_W'(INSN_LEN);
    assign cycles_o  = r_q.wide ? CYC_W'(WIDE_CYC) : CYC_W'(NARROW_CYC);

endmodule

// File: rtl/bitmod_rmw_unit.sv
module bitmod_rmw_unit #(
    parameter  int BYTE_W     = 8,
    parameter  int INSN_LEN   = 3,
    parameter  int NARROW_CYC = 6,
    parameter  int WIDE_CYC   = 7,
    localparam int ADDR_W     = 2 * BYTE_W,
    localparam int VAL_W      = 2 * BYTE_W,
    localparam int CYC_W      = $clog2(WIDE_CYC + 1),
    localparam int LEN_W      = $clog2(INSN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_set_i,
    input  logic              wide_i,
    input  logic [VAL_W-1:0]  acc_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              zero_o,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic [LEN_W-1:0]  bytes_o,
    output logic [CYC_W-1:0]  cycles_o
);

    logic [VAL_W-1:0] alu_val;
    logic [VAL_W-1:0] alu_acc;
    logic [VAL_W-1:0] alu_res;
    logic             alu_op_set;
    logic             alu_wide;
    logic             alu_zero;

    bitmod_ctrl #(
        .BYTE_W    (BYTE_W),
        .INSN_LEN  (INSN_LEN),
        .NARROW_CYC(NARROW_CYC),
        .WIDE_CYC  (WIDE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_set_i    (op_set_i),
        .wide_i      (wide_i),
        .acc_i       (acc_i),
        .pc_i        (pc_i),
        .mem_rdata_i (mem_rdata_i),
        .alu_result_i(alu_res),
        .alu_zero_i  (alu_zero),
        .alu_val_o   (alu_val),
        .alu_acc_o   (alu_acc),
        .alu_op_set_o(alu_op_set),
        .alu_wide_o  (alu_wide),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .zero_o      (zero_o),
        .pc_next_o   (pc_next_o),
        .bytes_o     (bytes_o),
        .cycles_o    (cycles_o)
    );

    bitmod_alu #(
        .BYTE_W(BYTE_W),
        .LANES (2)
    ) u_alu (
        .mem_val_i(alu_val),
        .acc_i    (alu_acc),
        .op_set_i (alu_op_set),
        .wide_i   (alu_wide),
        .result_o (alu_res),
        .zero_o   (alu_zero)
    );

endmodule

// File: rtl/bitmod_rmw_checker.sv
module bitmod_rmw_checker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 2,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] pc_next_o,
    input logic [LEN_W-1:0]  bytes_o,
    input logic [CYC_W-1:0]  cycles_o
);

    p_rst_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy_o && !done_o));

    p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !mem_wr_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_wr_o));

    p_done_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bytes_o == LEN_W'(3) && (cycles_o == CYC_W'(6) || cycles_o == CYC_W'(7))));

    p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pc_next_o));

endmodule

bind bitmod_rmw_unit bitmod_rmw_checker #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .CYC_W (CYC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .pc_next_o(pc_next_o),
    .bytes_o  (bytes_o),
    .cycles_o (cycles_o)
);

// File: tb/bitmod_rmw_unit_tb.sv
`timescale 1ns/1ps
module bitmod_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_set = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] acc = '0;
    logic [15:0] pc = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, zero;
    logic [15:0] pc_next;
    logic [1:0]  bytes;
    logic [2:0]  cycles;

    int n_chk = 0;
    int n_bad = 0;
    int wr_count = 0;
    int conflict_count = 0;

    logic [7:0] mem [0:1023];

    always #10 clk = ~clk;   // 50 MHz

    bitmod_rmw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_set_i(op_set),
        .wide_i(wide), .acc_i(acc), .pc_i(pc), .mem_addr_o(mem_addr),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .zero_o(zero),
        .pc_next_o(pc_next), .bytes_o(bytes), .cycles_o(cycles)
    );

    // Synchronous byte memory model, 10-bit index window.
    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_rd && mem_wr) conflict_count <= conflict_count + 1;
        if (!busy && (mem_rd || mem_wr)) conflict_count <= conflict_count + 1;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic place(input logic [15:0] p, input logic [15:0] opnd,
                         input logic [7:0] lo, input logic [7:0] hi);
        mem[10'(p + 16'd1)] = opnd[7:0];
        mem[10'(p + 16'd2)] = opnd[15:8];
        mem[opnd[9:0]] = lo;
        mem[10'(opnd + 16'd1)] = hi;
    endtask

    // Full operation with checks of timing, report and memory effect.
    task automatic do_case(input string req, input logic s, input logic w,
                           input logic [15:0] a, input logic [15:0] p,
                           input logic [15:0] opnd, input logic [7:0] lo,
                           input logic [7:0] hi, input logic [7:0] exp_lo,
                           input logic [7:0] exp_hi, input logic exp_z);
        int lat;
        int wc0;
        place(p, opnd, lo, hi);
        wc0 = wr_count;
        @(negedge clk);
        op_set = s; wide = w; acc = a; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check({req, " R9"}, "done latency", 32'(lat), w ? 32'd7 : 32'd5);
        check({req, " R5"}, "zero flag", 32'(zero), 32'(exp_z));
        check({req, " R8"}, "pc_next", 32'(pc_next), 32'(p + 16'd3));
        check({req, " R8"}, "bytes", 32'(bytes), 32'd3);
        check({req, " R8"}, "cycles", 32'(cycles), w ? 32'd7 : 32'd6);
        @(negedge clk);
        check({req, " R9"}, "done width", 32'(done), 32'd0);
        check(req, "low byte", 32'(mem[opnd[9:0]]), 32'(exp_lo));
        check(w ? {req, " R7"} : {req, " R6"}, "next byte",
              32'(mem[10'(opnd + 16'd1)]), w ? 32'(exp_hi) : 32'(hi));
        check(w ? "R7" : "R6", "write count", 32'(wr_count - wc0), w ? 32'd2 : 32'd1);
    endtask

    task automatic t_reset();
        check("R1", "busy in reset", 32'(busy), 32'd0);
        check("R1", "done in reset", 32'(done), 32'd0);
        check("R1", "access in reset", 32'(mem_rd | mem_wr), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "zero after reset", 32'(zero), 32'd0);
        check("R1", "busy after reset", 32'(busy), 32'd0);
    endtask

    task automatic t_busy_start();
        int wc0;
        int saw;
        place(16'h0200, 16'h0300, 8'hFF, 8'h11);
        place(16'h0250, 16'h0310, 8'hAA, 8'hBB);
        @(negedge clk);
        op_set = 1'b0; wide = 1'b0; acc = 16'h000F; pc = 16'h0200; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); pc = 16'h0250; op_set = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check("R11", "pc_next kept", 32'(pc_next), 32'h0203);
        start = 1'b1;          // arrives in the done cycle
        @(negedge clk); start = 1'b0;
        wc0 = wr_count;
        saw = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done || busy || mem_rd) saw = 1;
        end
        check("R11", "activity after ignored start", 32'(saw), 32'd0);
        check("R11", "writes after ignored start", 32'(wr_count - wc0), 32'd0);
        check("R4 R11", "first op result", 32'(mem[10'h300]), 32'hF0);
        check("R11", "second target untouched", 32'(mem[10'h310]), 32'hAA);
        check("R11", "pc_next after ignore", 32'(pc_next), 32'h0203);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        // R3 / R4 basic patterns, both widths
        do_case("R3", 1'b1, 1'b0, 16'h00CC, 16'h0010, 16'h0040, 8'hF0, 8'h5A, 8'hFC, 8'h5A, 1'b0);
        do_case("R4", 1'b0, 1'b0, 16'h00CC, 16'h0020, 16'h0050, 8'hF3, 8'h5A, 8'h33, 8'h5A, 1'b0);
        do_case("R3", 1'b1, 1'b1, 16'hCCCC, 16'h0030, 16'h0060, 8'hF0, 8'hF0, 8'hFC, 8'hFC, 1'b0);
        do_case("R4", 1'b0, 1'b1, 16'hCCCC, 16'h0080, 16'h00A0, 8'hF0, 8'hF0, 8'h30, 8'h30, 1'b0);
        // R5: flag set although the result is nonzero
        do_case("R5", 1'b1, 1'b0, 16'h000C, 16'h00B0, 16'h00C0, 8'h30, 8'h22, 8'h3C, 8'h22, 1'b1);
        do_case("R5", 1'b0, 1'b1, 16'h00FF, 16'h00D0, 16'h00E0, 8'h00, 8'h55, 8'h00, 8'h55, 1'b1);
        // R5: result zero but overlap nonzero, flag clear
        do_case("R5", 1'b0, 1'b0, 16'h00FF, 16'h0110, 16'h0120, 8'h0F, 8'h66, 8'h00, 8'h66, 1'b0);
        // R6: upper accumulator byte ignored in 8-bit mode
        do_case("R6", 1'b1, 1'b0, 16'hFF00, 16'h0130, 16'h0140, 8'h0F, 8'h77, 8'h0F, 8'h77, 1'b1);
        // R2: operand address wraps from 0xFFFF to 0x0000
        do_case("R2", 1'b1, 1'b1, 16'h0102, 16'h0100, 16'hFFFF, 8'h01, 8'h80, 8'h03, 8'h81, 1'b1);
        t_busy_start();
        check("R10", "access conflicts", 32'(conflict_count), 32'd0);
        summary();
        $finish;
    end

endmodule